// File: doc/BRIEF.md
# Burst Address Sequencing Controller

This block is the address and control front end of a synchronous pipelined burst memory. On every rising clock edge it samples three chip selects, two address strobes (one from a processor and one from a cache controller), an advance input and a write indication. From these it decides whether to load a new external address, step or hold an internal two-bit beat counter, or deselect the device.

Each cycle it produces one registered bundle for the downstream array datapath. The bundle holds a command (no-operation, read or write) and the full array address. The two low address bits follow a four-beat wrapping sequence. That sequence is linear or interleaved, as chosen by a static mode pin.

The processor strobe has priority over the controller strobe. The processor strobe is also blocked entirely while the first chip select is high. Continuation beats of a running burst need no strobe and no chip select. A deselect ends the burst.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high reset sets the command output to no-operation (code 0) and the address output to zero, and ends any running burst, so a following edge with both strobes high yields no-operation.
- R2: When the processor strobe is low and all three selects are active (first select low, second high, third low), the next bundle is a read (code 1) at the external address, whatever the controller strobe and the write indication are.
- R3: While the first select is high, the processor strobe has no effect: a running burst continues as if both strobes were high, and a controller strobe on that edge is treated as a deselect.
- R4: A controller-strobe start is taken only when the processor strobe is not in effect on the same edge. It loads the external address, and the write indication sampled on that same edge gives write (code 2) when low or read when high.
- R5: The write indication is ignored on an edge that takes the processor strobe. On the following continuation edges it is sampled: low gives write, high gives read.
- R6: The advance input is ignored on a loading edge. On a continuation edge, advance low steps to the next beat address and advance high repeats the current address.
- R7: When a strobe in effect is sampled while any select is inactive, the bundle is no-operation and the burst ends. Later edges without a strobe then yield no-operation.
- R8: With the mode pin low, the low two address bits are the start value plus the beat count modulo 4, so a fifth beat returns to the start value.
- R9: With the mode pin high, the low two address bits are the start value XOR the beat count, wrapping after four beats.
- R10: The address bits above the low two stay at the loaded value for the whole burst.
- R11: With no strobe in effect and no running burst, the bundle is no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| selA_n | input | 1 | First chip select, active low; also blocks the processor strobe |
| selB | input | 1 | Second chip select, active high |
| selC_n | input | 1 | Third chip select, active low |
| procStrobe_n | input | 1 | Processor address strobe, active low |
| ctrlStrobe_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| writeReq_n | input | 1 | Write indication, active low |
| modeIlv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| extAddr | input | ADDR_W | External start address |
| cmdOut | output | 2 | Registered command: 0 no-operation, 1 read, 2 write |
| addrOut | output | ADDR_W | Registered array address |

## Verification
The bench builds the block with ADDR_W set to 8. This keeps each address vector a two-digit hex value, while the upper six bits stay wide enough to show that they do not change during a burst. It drives linear and interleaved bursts from every start offset needed to reach both wrap points. It also covers the strobe-priority collisions, the first-select blocking case, deselects through each of the three selects, and a reset that lands in the middle of a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } seq_cmd_e;

  typedef struct packed {
    logic     load;
    logic     step;
    logic     keep;
    seq_cmd_e cmd;
  } seq_strobe_t;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        selA_n,
  input  logic        selB,
  input  logic        selC_n,
  input  logic        procStrobe_n,
  input  logic        ctrlStrobe_n,
  input  logic        advance_n,
  input  logic        writeReq_n,
  output seq_strobe_t strb
);

  logic activeQ;
  logic activeN;
  logic allSel;
  logic procHit;
  logic ctrlHit;

  assign allSel  = !selA_n && selB && !selC_n;
  assign procHit = !procStrobe_n && !selA_n;
  assign ctrlHit = !ctrlStrobe_n && !procHit;

  always_comb begin
    strb    = '{load: 1'b0, step: 1'b0, keep: 1'b0, cmd: CMD_NOP};
    activeN = activeQ;
    if (procHit) begin
      if (allSel) begin
        strb.load = 1'b1;
        strb.cmd  = CMD_READ;
        activeN   = 1'b1;
      end else begin
        activeN   = 1'b0;
      end
    end else if (ctrlHit) begin
      if (allSel) begin
        strb.load = 1'b1;
        strb.cmd  = writeReq_n ? CMD_READ : CMD_WRITE;
        activeN   = 1'b1;
      end else begin
        activeN   = 1'b0;
      end
    end else if (activeQ) begin
      strb.cmd  = writeReq_n ? CMD_READ : CMD_WRITE;
      strb.step = !advance_n;
      strb.keep = advance_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) activeQ <= 1'b0;
    else     activeQ <= activeN;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.load, strb.step, strb.keep})) else $error("strobe overlap"); // R6

  AST_IDLE_NOP: assert property (@(posedge clk) disable iff (rst)
    (!activeQ && procStrobe_n && ctrlStrobe_n) |-> (strb.cmd == CMD_NOP)) else $error("idle not nop"); // R11

endmodule

// File: rtl/burst_seq_datapath.sv
module burst_seq_datapath
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              modeIlv,
  input  logic [ADDR_W-1:0] extAddr,
  input  seq_strobe_t       strb,
  output logic [1:0]        cmdOut,
  output logic [ADDR_W-1:0] addrOut
);

  localparam int BEAT_W  = 2;
  localparam int UPPER_W = ADDR_W - BEAT_W;

  generate
    if (ADDR_W <= BEAT_W) begin : g_widthBad
      $error("ADDR_W must exceed the beat field");
    end
  endgenerate

  logic [UPPER_W-1:0] upperQ, upperN;
  logic [BEAT_W-1:0]  startQ, startN;
  logic [BEAT_W-1:0]  beatQ, beatN;
  logic [BEAT_W-1:0]  lowN;

  always_comb begin
    upperN = upperQ;
    startN = startQ;
    beatN  = beatQ;
    if (strb.load) begin
      upperN = extAddr[ADDR_W-1:BEAT_W];
      startN = extAddr[BEAT_W-1:0];
      beatN  = '0;
    end else if (strb.step) begin
      beatN  = beatQ + 1'b1;
    end
    lowN = modeIlv ? (startN ^ beatN) : (startN + beatN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upperQ  <= '0;
      startQ  <= '0;
      beatQ   <= '0;
      cmdOut  <= CMD_NOP;
      addrOut <= '0;
    end else begin
      upperQ <= upperN;
      startQ <= startN;
      beatQ  <= beatN;
      cmdOut <= strb.cmd;
      if (strb.load || strb.step || strb.keep) addrOut <= {upperN, lowN};
    end
  end

  AST_LOAD_TAKES_EXT: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> (addrOut == $past(extAddr))) else $error("load address"); // R4

  AST_HOLD_ON_SUSPEND: assert property (@(posedge clk) disable iff (rst)
    strb.keep |=> $stable(addrOut)) else $error("suspend moved"); // R6

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    strb.step |=> (addrOut[ADDR_W-1:BEAT_W] == $past(addrOut[ADDR_W-1:BEAT_W]))) else $error("upper moved"); // R10

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
    (strb.step && !modeIlv) |=> (addrOut[BEAT_W-1:0] == $past(addrOut[BEAT_W-1:0]) + 2'd1)) else $error("linear order"); // R8

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              selA_n,
  input  logic              selB,
  input  logic              selC_n,
  input  logic              procStrobe_n,
  input  logic              ctrlStrobe_n,
  input  logic              advance_n,
  input  logic              writeReq_n,
  input  logic              modeIlv,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [1:0]        cmdOut,
  output logic [ADDR_W-1:0] addrOut
);

  seq_strobe_t strb;

  burst_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .selA_n(selA_n), .selB(selB), .selC_n(selC_n),
    .procStrobe_n(procStrobe_n), .ctrlStrobe_n(ctrlStrobe_n),
    .advance_n(advance_n), .writeReq_n(writeReq_n),
    .strb(strb)
  );

  burst_seq_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst),
    .modeIlv(modeIlv), .extAddr(extAddr),
    .strb(strb),
    .cmdOut(cmdOut), .addrOut(addrOut)
  );

  AST_PROC_START_READ: assert property (@(posedge clk) disable iff (rst)
    (!procStrobe_n && !selA_n && selB && !selC_n)
      |=> (cmdOut == CMD_READ && addrOut == $past(extAddr))) else $error("proc start"); // R2

  AST_DESELECT_NOP: assert property (@(posedge clk) disable iff (rst)
    (!ctrlStrobe_n && !(!selA_n && selB && !selC_n)) |=> (cmdOut == CMD_NOP)) else $error("deselect"); // R7

endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NVEC = 23;

  logic clk = 1'b0;
  logic rst;
  logic selA_n, selB, selC_n, procStrobe_n, ctrlStrobe_n, advance_n, writeReq_n, modeIlv;
  logic [AW-1:0] extAddr;
  logic [1:0]    cmdOut;
  logic [AW-1:0] addrOut;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_burst_addr_seq (
    .clk(clk), .rst(rst),
    .selA_n(selA_n), .selB(selB), .selC_n(selC_n),
    .procStrobe_n(procStrobe_n), .ctrlStrobe_n(ctrlStrobe_n),
    .advance_n(advance_n), .writeReq_n(writeReq_n), .modeIlv(modeIlv),
    .extAddr(extAddr), .cmdOut(cmdOut), .addrOut(addrOut)
  );

  // layout: selA_n selB selC_n proc_n ctrl_n adv_n wr_n mode | ext | expCmd | expAddr | req
  function automatic logic [29:0] v(input logic sa, sb, sc, p, c, a, w, m,
                                    input logic [7:0] ext, input logic [1:0] ec,
                                    input logic [7:0] ea, input logic [3:0] rq);
    return {sa, sb, sc, p, c, a, w, m, ext, ec, ea, rq};
  endfunction

  localparam logic [29:0] VEC [NVEC] = '{
    v(0,1,0,0,0,0,0,0, 8'h46, 2'd1, 8'h46, 4'd2),  // R2 R5 R6 load, write and advance ignored
    v(0,1,0,1,1,0,1,0, 8'h00, 2'd1, 8'h47, 4'd8),  // R8
    v(0,1,0,1,1,0,1,0, 8'h00, 2'd1, 8'h44, 4'd8),  // R8 low bits wrap 3->0
    v(0,1,0,1,1,0,1,0, 8'h00, 2'd1, 8'h45, 4'd8),
    v(0,1,0,1,1,0,1,0, 8'h00, 2'd1, 8'h46, 4'd8),  // R8 fifth beat back to start
    v(0,1,0,1,1,1,1,0, 8'h00, 2'd1, 8'h46, 4'd6),  // R6 suspend
    v(0,1,0,1,1,0,0,0, 8'h00, 2'd2, 8'h47, 4'd5),  // R5 write sampled on continuation
    v(1,1,0,0,1,1,1,0, 8'h00, 2'd1, 8'h47, 4'd3),  // R3 proc strobe blocked
    v(0,0,0,1,0,0,1,0, 8'h00, 2'd0, 8'h00, 4'd7),  // R7 second select inactive
    v(0,1,0,1,1,0,1,0, 8'h00, 2'd0, 8'h00, 4'd11), // R11 burst ended
    v(0,1,0,1,0,0,0,0, 8'h91, 2'd2, 8'h91, 4'd4),  // R4 controller write start
    v(0,1,0,0,0,0,0,0, 8'h20, 2'd1, 8'h20, 4'd4),  // R4 processor wins collision
    v(0,1,0,0,1,0,1,1, 8'hB3, 2'd1, 8'hB3, 4'd2),
    v(0,1,0,1,1,0,1,1, 8'h00, 2'd1, 8'hB2, 4'd9),  // R9
    v(0,1,0,1,1,0,1,1, 8'h00, 2'd1, 8'hB1, 4'd9),
    v(0,1,0,1,1,0,1,1, 8'h00, 2'd1, 8'hB0, 4'd9),
    v(0,1,0,1,1,0,1,1, 8'h00, 2'd1, 8'hB3, 4'd9),  // R9 wrap
    v(1,1,0,0,0,0,1,1, 8'h00, 2'd0, 8'h00, 4'd3),  // R3 ctrl with first select high
    v(0,1,1,1,0,0,1,1, 8'h00, 2'd0, 8'h00, 4'd7),  // R7 third select inactive
    v(0,1,0,1,0,0,1,1, 8'h5A, 2'd1, 8'h5A, 4'd4),  // R4 controller read start
    v(0,1,0,1,1,0,1,1, 8'h00, 2'd1, 8'h5B, 4'd10), // R10 R9
    v(0,1,0,1,1,1,1,1, 8'h00, 2'd1, 8'h5B, 4'd6),  // R6
    v(0,0,0,0,1,0,1,1, 8'h00, 2'd0, 8'h00, 4'd7)   // R7 proc strobe, second select off
  };

  task automatic drive(input logic [29:0] x);
    {selA_n, selB, selC_n, procStrobe_n, ctrlStrobe_n, advance_n, writeReq_n, modeIlv} = x[29:22];
    extAddr = x[21:14];
  endtask

  task automatic check(input int req, input logic [1:0] expCmd,
                       input logic [AW-1:0] expAddr, input bit withAddr);
    checks++;
    if (cmdOut !== expCmd || (withAddr && addrOut !== expAddr)) begin
      errors++;
      $display("FAIL R%0d: cmd=%0d addr=%h expected cmd=%0d addr=%h", req, cmdOut, addrOut, expCmd, expAddr);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(v(0,1,0,1,1,1,1,0, 8'h00, 2'd0, 8'h00, 4'd0));
    repeat (2) @(posedge clk);
    #1 check(1, 2'd0, 8'h00, 1'b1);  // R1 reset state
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk) drive(VEC[i]);
      @(posedge clk);
      #1 check(int'(VEC[i][3:0]), VEC[i][13:12], VEC[i][11:4], VEC[i][13:12] != 2'd0);
    end

    // R1: reset in mid-burst clears output and ends burst
    @(negedge clk) drive(v(0,1,0,0,1,0,1,0, 8'h6D, 2'd1, 8'h6D, 4'd2));
    @(posedge clk);
    #1 check(2, 2'd1, 8'h6D, 1'b1);
    @(negedge clk) begin
      rst = 1'b1;
      drive(v(0,1,0,1,1,0,1,0, 8'h00, 2'd0, 8'h00, 4'd1));
    end
    @(posedge clk);
    #1 check(1, 2'd0, 8'h00, 1'b1);
    @(negedge clk) rst = 1'b0;
    @(posedge clk);
    #1 check(1, 2'd0, 8'h00, 1'b0);  // R1 no continuation after reset

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule